// File: doc/BRIEF.md
# Dual Bus Transaction Timeout Monitor

This block guards two independent buses, a system bus and a local bus, against transactions that are never answered. Each bus side presents a one-cycle transaction-start strobe and an acknowledge strobe. If the acknowledge does not arrive within a programmable number of clocks, the monitor for that bus raises a one-cycle transfer-error pulse. The user can then abort the transfer or log the fault.

A 32-bit protection control word configures both monitors. It holds an 8-bit timing value that sets the time-out in steps of eight clocks, and one enable bit per bus. It also stores a 16-bit watchdog count that nothing in this block uses. The word can be read at any time. It accepts exactly one write after each hard reset, so once the configuration is fixed, errant software cannot relax it.

Top module: `bus_txn_timeout_mon`

## Requirements
- R1: After hard reset the control word reads 0x00FF_FFFF: watchdog count bits [15:0] all ones, timing bits [23:16] all ones, system enable bit 24 and local enable bit 25 zero, bits [31:26] zero.
- R2: `reg_rdata` always shows the current control word, with no read strobe.
- R3: The first write after hard reset loads bits [25:0] from `reg_wdata`, and the new value is visible on `reg_rdata` in the cycle after the write. Bits [31:26] always read zero.
- R4: Every write after the first accepted one is ignored until the next hard reset.
- R5: For an enabled bus with timing value T, a start in cycle 0 with no acknowledge afterwards gives a transfer-error pulse exactly one cycle wide in cycle 8·T+1.
- R6: An acknowledge in any cycle from 1 to 8·T+1 ends the transaction with no error. This includes the time-out cycle itself, where the acknowledge wins.
- R7: With T = 0 and the bus enabled, a start with no acknowledge in its own cycle gives the error pulse in the following cycle, unless that cycle carries an acknowledge.
- R8: A bus whose enable bit is 0 never raises a transfer error, and starts seen while it is disabled are dropped.
- R9: Both buses use the same timing value but track their transactions independently.
- R10: A start in the same cycle as its acknowledge completes at once with no tracking. A start while a transaction is pending restarts the timing.
- R11: An acknowledge while no transaction is pending has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Hard reset, active low, asynchronous |
| reg_we | input | 1 | Control word write strobe |
| reg_wdata | input | 32 | Control word write data |
| reg_rdata | output | 32 | Current control word |
| sys_start | input | 1 | System bus transaction start |
| sys_ack | input | 1 | System bus acknowledge |
| sys_terr | output | 1 | System bus transfer-error pulse |
| loc_start | input | 1 | Local bus transaction start |
| loc_ack | input | 1 | Local bus acknowledge |
| loc_terr | output | 1 | Local bus transfer-error pulse |

## Verification
Directed cases cover four timing situations. The first lets a transaction run to its deadline, which tells an off-by-one in the eight-clock scaling apart from a correct count. The second places the acknowledge exactly in the time-out cycle, which shows whether the acknowledge wins. The third uses a zero timing value, which shows whether the error comes in the very next cycle. The fourth pairs a start with its own acknowledge, which separates immediate completion from tracking. Random rounds re-reset the block, pick small timing values and random enable pairs, and drive both buses with independent start and acknowledge traffic. These rounds expose interaction between the shared timing value and the two counters, restarts while pending, and stray acknowledges. Repeated writes after the first one show whether the write-once lock holds.

// File: rtl/btm_pkg.sv
package btm_pkg;
  localparam int REG_W      = 32;
  localparam int WDOG_W     = 16;
  localparam int TIM_W      = 8;
  localparam int UNIT_SHIFT = 3;                 // time-out granule = 2**UNIT_SHIFT clocks
  localparam int CNT_W      = TIM_W + UNIT_SHIFT;
  localparam int NUM_BUS    = 2;                 // index 0 = system bus, 1 = local bus

  // Packed from MSB: loc_en lands on bit 25, sys_en on 24, timing on 23:16, wdog on 15:0
  typedef struct packed {
    logic              loc_en;
    logic              sys_en;
    logic [TIM_W-1:0]  timing;
    logic [WDOG_W-1:0] wdog;
  } prot_cfg_t;

  localparam int CFG_W   = $bits(prot_cfg_t);
  localparam int UNUSED_W = REG_W - CFG_W;

  localparam prot_cfg_t CFG_RST = '{loc_en: 1'b0, sys_en: 1'b0,
                                    timing: '1, wdog: '1};

  // Number of clocks a transaction may stay unanswered
  function automatic logic [CNT_W-1:0] timeout_load(input logic [TIM_W-1:0] t);
    return {t, {UNIT_SHIFT{1'b0}}};
  endfunction

  function automatic logic [REG_W-1:0] cfg_to_word(input prot_cfg_t c);
    return {{UNUSED_W{1'b0}}, c};
  endfunction

  function automatic prot_cfg_t word_to_cfg(input logic [REG_W-1:0] w);
    return prot_cfg_t'(w[CFG_W-1:0]);
  endfunction
endpackage

// File: rtl/btm_ctrl_reg.sv
module btm_ctrl_reg
  import btm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output prot_cfg_t        cfg,
  output logic             locked,
  output logic             wr_accept
);
  prot_cfg_t cfg_q;
  logic      locked_q;

  assign wr_accept = wr_en && !locked_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= CFG_RST;
      locked_q <= 1'b0;
    end else if (wr_accept) begin
      cfg_q    <= word_to_cfg(wr_data);
      locked_q <= 1'b1;
    end
  end

  assign cfg     = cfg_q;
  assign locked  = locked_q;
  assign rd_data = cfg_to_word(cfg_q);
endmodule

// File: rtl/btm_bus_mon.sv
module btm_bus_mon
  import btm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [TIM_W-1:0] timing,
  input  logic             start,
  input  logic             ack,
  output logic             terr,
  output logic             pending
);
  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic             expired;

  assign expired = busy_q && (cnt_q == '0);
  assign terr    = enable && expired && !ack;
  assign pending = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!enable) begin
      busy_q <= 1'b0;
    end else if (start) begin
      busy_q <= !ack;
      cnt_q  <= timeout_load(timing);
    end else if (busy_q && (ack || expired)) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/bus_txn_timeout_mon.sv
module bus_txn_timeout_mon
  import btm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             sys_start,
  input  logic             sys_ack,
  output logic             sys_terr,
  input  logic             loc_start,
  input  logic             loc_ack,
  output logic             loc_terr
);
  prot_cfg_t          cfg;
  logic               locked;
  logic               wr_accept;
  logic               timing_zero;
  logic [NUM_BUS-1:0] bus_start, bus_ack, bus_en, bus_terr, bus_pend;

  btm_ctrl_reg u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (reg_we),
    .wr_data   (reg_wdata),
    .rd_data   (reg_rdata),
    .cfg       (cfg),
    .locked    (locked),
    .wr_accept (wr_accept)
  );

  assign timing_zero = (cfg.timing == '0);
  assign bus_start   = {loc_start, sys_start};
  assign bus_ack     = {loc_ack, sys_ack};
  assign bus_en      = {cfg.loc_en, cfg.sys_en};

  for (genvar g = 0; g < NUM_BUS; g++) begin : g_mon
    btm_bus_mon u_mon (
      .clk     (clk),
      .rst_n   (rst_n),
      .enable  (bus_en[g]),
      .timing  (cfg.timing),
      .start   (bus_start[g]),
      .ack     (bus_ack[g]),
      .terr    (bus_terr[g]),
      .pending (bus_pend[g])
    );
  end

  assign sys_terr = bus_terr[0];
  assign loc_terr = bus_terr[1];
endmodule

// File: rtl/btm_checks.sv
module btm_checks
  import btm_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [REG_W-1:0]   reg_rdata,
  input logic               locked,
  input logic               wr_accept,
  input logic               timing_zero,
  input logic [NUM_BUS-1:0] en,
  input logic [NUM_BUS-1:0] start,
  input logic [NUM_BUS-1:0] ack,
  input logic [NUM_BUS-1:0] terr,
  input logic [NUM_BUS-1:0] pend
);
  // R3
  accept_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> locked);

  // R4
  lock_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);

  // R4
  word_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(reg_rdata));

  for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus
    // R8
    terr_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      terr[b] |-> en[b]);

    // R6
    ack_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      terr[b] |-> !ack[b]);

    // R5
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      terr[b] |=> (!terr[b] || $past(start[b])));

    // R7
    zero_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en[b] && timing_zero && start[b] && !ack[b]) |=> (terr[b] || ack[b]));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pend[b] && !start[b]) |=> !terr[b]);

    // R10
    instant_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start[b] && ack[b]) |=> !pend[b]);
  end
endmodule

bind bus_txn_timeout_mon btm_checks u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_rdata   (reg_rdata),
  .locked      (locked),
  .wr_accept   (wr_accept),
  .timing_zero (timing_zero),
  .en          (bus_en),
  .start       (bus_start),
  .ack         (bus_ack),
  .terr        (bus_terr),
  .pend        (bus_pend)
);

// File: tb/test_bus_txn_timeout_mon.sv
module test_bus_txn_timeout_mon;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        sys_start = 1'b0, sys_ack = 1'b0, loc_start = 1'b0, loc_ack = 1'b0;
  logic        sys_terr, loc_terr;

  always #4 clk = ~clk;   // 125 MHz

  bus_txn_timeout_mon i_bus_txn_timeout_mon (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .sys_start(sys_start), .sys_ack(sys_ack),
    .sys_terr(sys_terr), .loc_start(loc_start), .loc_ack(loc_ack),
    .loc_terr(loc_terr));

  int    checks = 0, fails = 0;
  int    seen[2];
  string cur_req = "R5";
  bit    done = 1'b0;

  logic [31:0] m_word;
  bit          m_locked;
  bit          m_busy[2];
  int          m_el[2], m_dl[2];

  // Independent restatement: error visible at elapsed == 8*T + 1 cycles after start
  function automatic int deadline(input logic [7:0] t);
    return int'(t) * 8 + 1;
  endfunction

  function automatic bit m_en(input int b);
    return m_word[24 + b];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input bit we, input logic [31:0] wd,
                      input bit ss, input bit sa, input bit ls, input bit la);
    bit st[2], ak[2], ter[2], ex;
    reg_we = we; reg_wdata = wd;
    sys_start = ss; sys_ack = sa; loc_start = ls; loc_ack = la;
    st[0] = ss; st[1] = ls; ak[0] = sa; ak[1] = la;
    #1;
    ter[0] = sys_terr; ter[1] = loc_terr;
    for (int b = 0; b < 2; b++) begin
      ex = m_en(b) && m_busy[b] && (m_el[b] == m_dl[b]) && !ak[b];
      chk(ter[b] == ex, cur_req, {31'd0, ter[b]}, {31'd0, ex});
      if (ter[b]) seen[b]++;
    end
    chk(reg_rdata == m_word, "R2", reg_rdata, m_word);
    @(posedge clk);
    for (int b = 0; b < 2; b++) begin
      if (!m_en(b)) m_busy[b] = 1'b0;
      else if (st[b]) begin
        m_busy[b] = !ak[b];
        m_el[b]   = 1;
        m_dl[b]   = deadline(m_word[23:16]);
      end else if (m_busy[b] && (ak[b] || m_el[b] == m_dl[b])) m_busy[b] = 1'b0;
      else if (m_busy[b]) m_el[b]++;
    end
    if (we && !m_locked) begin
      m_word   = {6'd0, wd[25:0]};
      m_locked = 1'b1;
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic hard_reset();
    reg_we = 0; sys_start = 0; sys_ack = 0; loc_start = 0; loc_ack = 0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    m_word = 32'h00FF_FFFF; m_locked = 1'b0;
    for (int b = 0; b < 2; b++) begin m_busy[b] = 0; m_el[b] = 0; m_dl[b] = 0; end
    rst_n = 1'b1;
    #1;
    chk(reg_rdata == 32'h00FF_FFFF, "R1", reg_rdata, 32'h00FF_FFFF);
    chk({sys_terr, loc_terr} == 2'b00, "R1", {30'd0, sys_terr, loc_terr}, 32'd0);
    @(negedge clk);
  endtask

  function automatic logic [31:0] cfg_word(input bit le, input bit se, input logic [7:0] t, input logic [15:0] w);
    return {6'd0, le, se, t, w};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    hard_reset();

    // R8: disabled after reset, starts dropped
    cur_req = "R8"; seen = '{0, 0};
    step(0, '0, 1, 0, 1, 0);
    idle(30);
    chk(seen[0] + seen[1] == 0, "R8", seen[0] + seen[1], 0);

    // R3: first write lands, upper bits read zero
    cur_req = "R3";
    step(1, 32'hFF02_1234, 0, 0, 0, 0);
    chk(reg_rdata == 32'h0302_1234, "R3", reg_rdata, 32'h0302_1234);

    // R4: later write ignored
    cur_req = "R4";
    step(1, 32'h0000_0000, 0, 0, 0, 0);
    chk(reg_rdata == 32'h0302_1234, "R4", reg_rdata, 32'h0302_1234);

    // R5: T=2, no ack, pulse in cycle 17
    cur_req = "R5"; seen = '{0, 0};
    step(0, '0, 1, 0, 0, 0);
    idle(25);
    chk(seen[0] == 1, "R5", seen[0], 1);

    // R6: ack in the time-out cycle wins
    cur_req = "R6"; seen = '{0, 0};
    step(0, '0, 1, 0, 1, 0);
    idle(16);
    step(0, '0, 0, 1, 0, 0);
    idle(6);
    chk(seen[0] == 0 && seen[1] == 1, "R6", {seen[0][15:0], seen[1][15:0]}, 32'h0000_0001);

    // R9: independent tracking, shared timing
    cur_req = "R9"; seen = '{0, 0};
    step(0, '0, 1, 0, 0, 0);
    idle(4);
    step(0, '0, 0, 1, 1, 0);
    idle(25);
    chk(seen[0] == 0 && seen[1] == 1, "R9", {seen[0][15:0], seen[1][15:0]}, 32'h0000_0001);

    // R10: start with ack completes; restart while pending
    cur_req = "R10"; seen = '{0, 0};
    step(0, '0, 1, 1, 0, 0);
    idle(25);
    step(0, '0, 0, 0, 1, 0);
    idle(10);
    step(0, '0, 0, 0, 1, 0);
    idle(25);
    chk(seen[0] == 0 && seen[1] == 1, "R10", {seen[0][15:0], seen[1][15:0]}, 32'h0000_0001);

    // R11: stray acknowledges while idle
    cur_req = "R11"; seen = '{0, 0};
    step(0, '0, 0, 1, 0, 1);
    step(0, '0, 0, 1, 0, 1);
    idle(5);
    chk(seen[0] + seen[1] == 0, "R11", seen[0] + seen[1], 0);

    // R7: zero timing
    hard_reset();
    cur_req = "R7"; seen = '{0, 0};
    step(1, cfg_word(1, 1, 8'h00, 16'h0), 0, 0, 0, 0);
    step(0, '0, 1, 0, 1, 0);
    step(0, '0, 0, 0, 0, 1);
    chk(seen[0] == 1 && seen[1] == 0, "R7", {seen[0][15:0], seen[1][15:0]}, 32'h0001_0000);
    idle(3);

    // Random rounds
    cur_req = "R5";
    for (int r = 0; r < 8; r++) begin
      hard_reset();
      step(1, cfg_word(1'($urandom), 1'($urandom), 8'($urandom % 5), 16'($urandom)), 0, 0, 0, 0);
      for (int i = 0; i < 1500; i++) begin
        step(($urandom % 7) == 0, $urandom,
             ($urandom % 10) == 0, ($urandom % 12) == 0,
             ($urandom % 10) == 0, ($urandom % 12) == 0);
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule